// File: doc/BRIEF.md
# Rectangular Block-Transfer Engine

This block moves or fills a rectangle of pixels inside a linear frame buffer on its own, without the host touching each pixel. The host sets up the job by writing byte-wide registers: source and destination byte addresses, rectangle width and height, line pitch, pixel depth, an operation code and a foreground colour. It then writes the start bit and polls the same bit until the engine clears it. A one-cycle `done` strobe marks the cycle in which the engine goes idle.

The engine handles one pixel at a time over a 16-bit word memory port that uses a valid/ready handshake. The engine raises `mem_valid` and holds the address, direction, byte enables and write data steady until `mem_ready` is sampled high. That edge completes the transfer. For a read, `mem_rdata` must be valid in that same cycle. The memory may hold `mem_ready` low for as long as it likes, and the engine just waits.

A move may walk forwards or backwards, and the opcode picks which. In a backward move the programmed addresses name the last pixel of the rectangle, which is the rightmost pixel of the bottom row. This lets a move whose destination lies above or to the left of an overlapping source, or the reverse, run in the safe order. At 8 bits per pixel, every write carries exactly one byte enable, so the neighbouring byte of the same word is never touched.

Top module: `blit_engine`

## Requirements
- R1: After reset, every register reads 0x00, the busy bit reads 0, `done` is low and `mem_valid` is low.
- R2: Register offsets are: 0 control (bit 7 start/busy, other bits plain storage), 1 depth, 2 opcode, 3..5 source address low/mid/high, 6..8 destination address low/mid/high, 9..10 width, 11..12 height, 13..14 pitch, 15..16 colour low/high. Offsets 1 to 16 read back what was last written.
- R3: A write to offset 0 with bit 7 set, while idle and with a supported opcode, starts a job. Bit 7 of offset 0 then reads 1 until the job ends, and `done` is high for exactly one cycle: the cycle in which bit 7 first reads 0 again.
- R4: Opcode 0x02 copies each pixel of the rectangle from source to destination, stepping right within a row and one pitch down per row. It issues exactly width×height reads.
- R5: Opcode 0x03 copies with both addresses pointing at the last pixel and walks left within a row and one pitch up per row. A copy whose destination overlaps the source further along gives the same result as copying from an unmodified snapshot.
- R6: Opcode 0x0C writes the colour register to every destination pixel (only its low byte at 8 bits per pixel) and issues no memory reads.
- R7: Bit 0 of offset 1 selects 16 bits per pixel when 1 and 8 when 0. At 8 bits, byte address bit 0 selects the lane (0 means data bits 7:0). Each write enables exactly that lane, and the other byte of the word is unchanged.
- R8: The width and height fields are 16-bit values, low byte at the lower offset, holding the pixel count minus one. The pitch field holds the line stride in 16-bit words.
- R9: While busy, all register writes, including a second start, are ignored. Their targets read back unchanged afterwards, and the job uses the values it started with.
- R10: A start with an opcode other than 0x02, 0x03 or 0x0C is ignored: busy stays 0, `done` stays low and no memory request is made.
- R11: `mem_valid` is low whenever the engine is idle. A request that is not accepted keeps its address, direction, enables and data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| done | output | 1 | One-cycle strobe when a job finishes |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-1 | 16-bit word address |
| mem_be | output | 2 | Byte enables for writes |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the accepting cycle |

## Verification
A wrong pixel counter or address stepper first shows as a memory image that differs from the arithmetic model. That difference appears in the very job that misbehaves, because the whole frame buffer is compared after every job. A stuck sequencer state shows as a busy bit that never clears, which the bench's poll limit reports within a few thousand cycles. A wrong lane or byte-enable choice corrupts the neighbouring byte of an odd- or even-aligned 8-bit pixel, so the sweep moves rectangle origins across both alignments. A broken handshake shows at the port itself, in the cycle after a stalled request.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int NUM_REGS = 17;

  localparam logic [4:0] RA_CTRL  = 5'd0;
  localparam logic [4:0] RA_DEPTH = 5'd1;
  localparam logic [4:0] RA_OPC   = 5'd2;
  localparam logic [4:0] RA_SRC   = 5'd3;
  localparam logic [4:0] RA_DST   = 5'd6;
  localparam logic [4:0] RA_WID   = 5'd9;
  localparam logic [4:0] RA_HGT   = 5'd11;
  localparam logic [4:0] RA_PITCH = 5'd13;
  localparam logic [4:0] RA_COLOR = 5'd15;

  localparam logic [7:0] OPC_MOVE_UP   = 8'h02;
  localparam logic [7:0] OPC_MOVE_DOWN = 8'h03;
  localparam logic [7:0] OPC_FILL      = 8'h0C;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } seq_state_t;

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              busy,
  output logic              start,
  output logic              wide,
  output logic              op_fill,
  output logic              op_rev,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [CNT_W-1:0]  width_m1,
  output logic [CNT_W-1:0]  height_m1,
  output logic [CNT_W-1:0]  pitch_words,
  output logic [15:0]       color
);

  logic [7:0] regs_q [NUM_REGS];
  logic       in_map;
  logic       op_ok;
  logic [7:0] opc;
  logic [23:0] src24, dst24;

  assign in_map = reg_addr < 5'(NUM_REGS);
  assign opc    = regs_q[RA_OPC];
  assign op_ok  = (opc == OPC_MOVE_UP) || (opc == OPC_MOVE_DOWN) || (opc == OPC_FILL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= 8'h00;
    end else if (reg_wr && !busy && in_map) begin
      if (reg_addr == RA_CTRL) regs_q[RA_CTRL] <= {1'b0, reg_wdata[6:0]};
      else                     regs_q[reg_addr] <= reg_wdata;
    end
  end

  assign start = reg_wr && !busy && (reg_addr == RA_CTRL) && reg_wdata[7] && op_ok;

  always_comb begin
    reg_rdata = 8'h00;
    if (in_map) reg_rdata = regs_q[reg_addr];
    if (reg_addr == RA_CTRL) reg_rdata = {busy, regs_q[RA_CTRL][6:0]};
  end

  assign src24 = {regs_q[RA_SRC+5'd2], regs_q[RA_SRC+5'd1], regs_q[RA_SRC]};
  assign dst24 = {regs_q[RA_DST+5'd2], regs_q[RA_DST+5'd1], regs_q[RA_DST]};

  assign wide        = regs_q[RA_DEPTH][0];
  assign op_fill     = opc == OPC_FILL;
  assign op_rev      = opc == OPC_MOVE_DOWN;
  assign src_base    = src24[ADDR_W-1:0];
  assign dst_base    = dst24[ADDR_W-1:0];
  assign width_m1    = CNT_W'({regs_q[RA_WID+5'd1],   regs_q[RA_WID]});
  assign height_m1   = CNT_W'({regs_q[RA_HGT+5'd1],   regs_q[RA_HGT]});
  assign pitch_words = CNT_W'({regs_q[RA_PITCH+5'd1], regs_q[RA_PITCH]});
  assign color       = {regs_q[RA_COLOR+5'd1], regs_q[RA_COLOR]};

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   step,
  input  logic                   wide,
  input  logic                   rev,
  input  logic [1:0][ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]       pitch_words,
  input  logic [CNT_W-1:0]       width_m1,
  input  logic [CNT_W-1:0]       height_m1,
  output logic [1:0][ADDR_W-1:0] cur,
  output logic                   last
);

  logic [CNT_W-1:0]  col_q, row_q;
  logic              row_end;
  logic [ADDR_W-1:0] px_delta, row_delta;

  assign row_end   = col_q == width_m1;
  assign last      = row_end && (row_q == height_m1);
  assign px_delta  = wide ? ADDR_W'(2) : ADDR_W'(1);
  assign row_delta = ADDR_W'({pitch_words, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (load) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (row_end) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [ADDR_W-1:0] row_start_q, cur_q, next_px, next_row;

    assign next_px  = rev ? cur_q - px_delta : cur_q + px_delta;
    assign next_row = rev ? row_start_q - row_delta : row_start_q + row_delta;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_start_q <= '0;
        cur_q       <= '0;
      end else if (load) begin
        row_start_q <= base[ch];
        cur_q       <= base[ch];
      end else if (step) begin
        if (row_end) begin
          row_start_q <= next_row;
          cur_q       <= next_row;
        end else begin
          cur_q <= next_px;
        end
      end
    end

    assign cur[ch] = cur_q;
  end

endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_fill,
  input  logic              wide,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              last,
  input  logic [15:0]       color,
  output logic              load,
  output logic              step,
  output logic              busy,
  output logic              done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);

  seq_state_t state_q;
  logic [15:0] hold_q;
  logic [15:0] pixel;
  logic        wr_ok;

  assign wr_ok = (state_q == ST_WRITE) && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= wr_ok && last;
      case (state_q)
        ST_IDLE: if (start) state_q <= op_fill ? ST_WRITE : ST_READ;
        ST_READ: if (mem_ready) begin
          if (wide)             hold_q <= mem_rdata;
          else if (src_addr[0]) hold_q <= {8'h00, mem_rdata[15:8]};
          else                  hold_q <= {8'h00, mem_rdata[7:0]};
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (mem_ready) begin
          if (last)         state_q <= ST_IDLE;
          else if (op_fill) state_q <= ST_WRITE;
          else              state_q <= ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load      = start && (state_q == ST_IDLE);
  assign step      = wr_ok && !last;
  assign busy      = state_q != ST_IDLE;
  assign mem_valid = busy;
  assign mem_we    = state_q == ST_WRITE;
  assign mem_addr  = mem_we ? dst_addr[ADDR_W-1:1] : src_addr[ADDR_W-1:1];
  assign pixel     = op_fill ? color : hold_q;
  assign mem_wdata = wide ? pixel : {pixel[7:0], pixel[7:0]};

  always_comb begin
    if (!mem_we || wide) mem_be = 2'b11;
    else if (dst_addr[0]) mem_be = 2'b10;
    else                  mem_be = 2'b01;
  end

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);

  logic              busy, start, wide, op_fill, op_rev, load, step, last;
  logic [ADDR_W-1:0] src_base, dst_base;
  logic [CNT_W-1:0]  width_m1, height_m1, pitch_words;
  logic [15:0]       color;
  logic [1:0][ADDR_W-1:0] cur;

  blit_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .start(start),
    .wide(wide), .op_fill(op_fill), .op_rev(op_rev), .src_base(src_base),
    .dst_base(dst_base), .width_m1(width_m1), .height_m1(height_m1),
    .pitch_words(pitch_words), .color(color)
  );

  blit_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .wide(wide),
    .rev(op_rev), .base({dst_base, src_base}), .pitch_words(pitch_words),
    .width_m1(width_m1), .height_m1(height_m1), .cur(cur), .last(last)
  );

  blit_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_fill(op_fill), .wide(wide),
    .src_addr(cur[0]), .dst_addr(cur[1]), .last(last), .color(color),
    .load(load), .step(step), .busy(busy), .done(done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wide,
  input logic              done,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-2:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic [15:0]       mem_wdata
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_be) && $stable(mem_wdata)); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3

  AST_NARROW_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && !wide |-> $countones(mem_be) == 1); // R7

  AST_WIDE_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && wide |-> mem_be == 2'b11); // R7

endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wide(wide), .done(done),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
);

// File: tb/tb_blit_engine.sv
`timescale 1ns/1ps
module tb_blit_engine;

  localparam int ADDR_W = 24;
  localparam int PITCH_W = 16;
  localparam int PB = PITCH_W * 2;
  localparam int NBYTES = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        done;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [ADDR_W-2:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  logic [15:0] mem  [NBYTES/2];
  logic [7:0]  refm [NBYTES];
  logic [7:0]  snap [NBYTES];

  int checks = 0, errors = 0, cyc = 0;
  int rd_cnt = 0, valid_cnt = 0, done_cnt = 0;
  logic [7:0] lfsr = 8'hA5;
  bit stall_en = 1'b0;

  always #5 clk = ~clk;

  blit_engine #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[8:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_valid) valid_cnt <= valid_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (mem_valid && mem_ready && !mem_we) rd_cnt <= rd_cnt + 1;
    if (mem_valid && mem_ready && mem_we) begin
      if (mem_be[0]) mem[mem_addr[8:0]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr[8:0]][15:8] <= mem_wdata[15:8];
    end
  end

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = stall_en ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run did not complete (actual %0d cycles, expected fewer)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic compare_mem(input string req);
    int bad = -1;
    logic [15:0] e, a;
    for (int i = 0; i < NBYTES/2; i++) begin
      if (bad < 0 && mem[i] !== {refm[2*i+1], refm[2*i]}) bad = i;
    end
    if (bad >= 0) begin
      a = mem[bad]; e = {refm[2*bad+1], refm[2*bad]};
    end else begin
      a = 16'h0; e = 16'h0;
    end
    chk(bad < 0, req, $sformatf("frame buffer word %0d", bad), a, e);
  endtask

  // Programs a job, starts it, optionally disturbs it, waits for it and checks it.
  task automatic run_op(input logic [7:0] op, input bit wd, input int sx, input int sy,
                        input int dx, input int dy, input int w, input int h,
                        input logic [15:0] colr, input bit meddle, input string req);
    int bpp = wd ? 2 : 1;
    int sa = sy * PB + sx * bpp;
    int da = dy * PB + dx * bpp;
    int rd0, polls;
    int dn0;
    logic [7:0] v;
    if (op == 8'h03) begin
      sa = sa + (h - 1) * PB + (w - 1) * bpp;
      da = da + (h - 1) * PB + (w - 1) * bpp;
    end
    wr(5'd1, {7'd0, wd});
    wr(5'd2, op);
    wr(5'd3, 8'(sa)); wr(5'd4, 8'(sa >> 8)); wr(5'd5, 8'(sa >> 16));
    wr(5'd6, 8'(da)); wr(5'd7, 8'(da >> 8)); wr(5'd8, 8'(da >> 16));
    wr(5'd9, 8'(w - 1));  wr(5'd10, 8'((w - 1) >> 8));
    wr(5'd11, 8'(h - 1)); wr(5'd12, 8'((h - 1) >> 8));
    wr(5'd13, 8'(PITCH_W)); wr(5'd14, 8'(PITCH_W >> 8));
    wr(5'd15, colr[7:0]); wr(5'd16, colr[15:8]);
    wr(5'd0, 8'h00);
    rd0 = rd_cnt; dn0 = done_cnt;
    wr(5'd0, 8'h80);
    rd(5'd0, v);
    chk(v[7] == 1'b1, "R3", "busy bit after start", v[7], 1);
    if (meddle) begin
      wr(5'd15, ~colr[7:0]);
      wr(5'd2, 8'h02);
      wr(5'd0, 8'h80);
    end
    polls = 0;
    rd(5'd0, v);
    while (v[7] && polls < 3000) begin
      @(negedge clk);
      polls++;
      rd(5'd0, v);
    end
    chk(v[7] == 1'b0, "R3", "busy cleared", v[7], 0);
    @(negedge clk);
    chk(done_cnt - dn0 == 1, "R3", "done pulses per job", done_cnt - dn0, 1);
    if (op == 8'h0C)
      chk(rd_cnt == rd0, "R6", "fill read count", rd_cnt - rd0, 0);
    else
      chk(rd_cnt - rd0 == w * h, "R4", "copy read count", rd_cnt - rd0, w * h);
    if (meddle) begin
      rd(5'd15, v);
      chk(v == colr[7:0], "R9", "colour after busy write", v, colr[7:0]);
      rd(5'd2, v);
      chk(v == op, "R9", "opcode after busy write", v, op);
    end
    // reference: every destination pixel takes the value of the unmodified source
    for (int i = 0; i < NBYTES; i++) snap[i] = refm[i];
    begin
      int fs = sy * PB + sx * bpp;
      int fd = dy * PB + dx * bpp;
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          for (int k = 0; k < bpp; k++) begin
            if (op == 8'h0C) refm[fd + r*PB + c*bpp + k] = (k == 0) ? colr[7:0] : colr[15:8];
            else refm[fd + r*PB + c*bpp + k] = snap[fs + r*PB + c*bpp + k];
          end
    end
    compare_mem(req);
  endtask

  initial begin
    logic [7:0] v;
    int v0, d0;
    bit ok;
    for (int i = 0; i < NBYTES; i++) refm[i] = pat(i);
    for (int i = 0; i < NBYTES/2; i++) mem[i] = {pat(2*i+1), pat(2*i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    ok = 1'b1;
    for (int a = 0; a < 17; a++) begin
      rd(5'(a), v);
      if (v != 8'h00) ok = 1'b0;
    end
    chk(ok, "R1", "registers after reset", ok, 1);
    chk(!mem_valid && !done, "R1", "valid/done after reset", {mem_valid, done}, 0);

    // R2: register readback
    ok = 1'b1;
    for (int a = 1; a < 17; a++) wr(5'(a), 8'(8'h40 + a));
    for (int a = 1; a < 17; a++) begin
      rd(5'(a), v);
      if (v != 8'(8'h40 + a)) ok = 1'b0;
    end
    chk(ok, "R2", "register readback", ok, 1);
    wr(5'd0, 8'h35);
    rd(5'd0, v);
    chk(v == 8'h35, "R2", "control readback", v, 8'h35);

    // R10 + R11: unsupported opcode start is ignored and memory stays quiet
    wr(5'd2, 8'h05);
    v0 = valid_cnt; d0 = done_cnt;
    wr(5'd0, 8'h80);
    rd(5'd0, v);
    chk(v[7] == 1'b0, "R10", "busy after bad opcode start", v[7], 0);
    repeat (5) @(negedge clk);
    chk(valid_cnt == v0, "R11", "requests while idle", valid_cnt - v0, 0);
    chk(done_cnt == d0, "R10", "done after bad opcode", done_cnt - d0, 0);
    compare_mem("R10");

    // Sweep R4/R5/R6/R7/R8 over depth, opcode, width and height
    stall_en = 1'b1;
    for (int wd = 0; wd < 2; wd++)
      for (int oi = 0; oi < 3; oi++)
        for (int w = 1; w <= 3; w++)
          for (int h = 1; h <= 3; h++) begin
            logic [7:0] op;
            int sx = (w + h + oi) % 4 + 1;
            int dx = (w + 2 * h + wd) % 5;
            op = (oi == 0) ? 8'h02 : (oi == 1) ? 8'h03 : 8'h0C;
            run_op(op, wd[0], sx, 1 + (h % 2), dx, 8 + oi, w, h,
                   16'(16'hA500 + 16'(w * 16 + h + oi)), 1'b0,
                   (oi == 2) ? "R6/R7/R8" : (oi == 1) ? "R5/R7/R8" : "R4/R7/R8");
          end

    // R5: overlapping backward move, destination further along
    run_op(8'h03, 1'b0, 2, 14, 3, 15, 3, 3, 16'h0, 1'b0, "R5");
    run_op(8'h03, 1'b1, 1, 17, 2, 18, 3, 2, 16'h0, 1'b0, "R5");
    // R4: overlapping forward move, destination earlier
    run_op(8'h02, 1'b0, 5, 21, 4, 20, 3, 3, 16'h0, 1'b0, "R4");
    // R9: writes and restart during a long fill are ignored
    run_op(8'h0C, 1'b1, 0, 0, 1, 25, 8, 3, 16'h5AC3, 1'b1, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule